// File: doc/BRIEF.md
# Tachometer Timer Register File

This block is the bus-facing register window and interrupt logic of a two-channel tachometer timer. A simple request/response port reaches fifteen registers inside a 32-byte address window. Each register accepts exactly one access width: the counter, capture and compare registers take only halfword (16-bit) accesses, and every other register takes only byte (8-bit) accesses. Any access with the wrong width, to an odd address or to an unmapped offset is refused with a one-cycle error response. A refused access reads as zero and changes nothing.

The capture channels sit outside this block. They signal six kinds of event: capture, underflow and compare on channel A and on channel B. They also load fresh counter and capture values through update strobes. Each event sets a pending bit. Software clears pending bits by writing ones to a separate write-only clear register, and the pending register itself ignores bus writes. An enable register selects which pending bits drive the single level interrupt output. Configuration registers (prescaler, clock control, mode, compare values, compare configuration and input selects) are presented on output ports to the channels.

Top module: `tach_regfile`

## Requirements
- R1: A request is legal only when the address is even and its halfword index is 0 to 14, and the width matches the register. Halfword-only registers are at offsets 0x00, 0x02, 0x04, 0x06, 0x14 and 0x16. Byte-only registers are at 0x08, 0x0A, 0x0C, 0x0E, 0x10, 0x12, 0x18, 0x1A and 0x1C. `req_wide`=1 means a halfword access and 0 means a byte access. An illegal request gives `rsp_err`=1 for one cycle with `rsp_rdata`=0.
- R2: An illegal write changes no register and no output.
- R3: A reset clears the prescaler (0x08), clock control (0x0A), mode (0x0C), pending (0x0E), enable (0x12), compare A/B (0x14/0x16), compare configuration (0x18) and input selects (0x1A/0x1C). It also clears `irq_o`, `rsp_valid` and `rsp_err`.
- R4: Counter 1 (0x00), capture A (0x02), capture B (0x04) and counter 2 (0x06) keep their contents across a reset.
- R5: The pending register at 0x0E maps its bits as follows: bit 0 capture A, bit 1 capture B, bit 2 underflow A, bit 3 underflow B, bit 4 compare A, bit 5 compare B. `evt_i[k]` high at a clock edge sets pending bit k at that edge. Bits 7:6 read as 0.
- R6: A byte write to the clear register at 0x10 clears each pending bit whose data bit is 1 and leaves the others. A read of 0x10 returns 0 without an error.
- R7: When an event and a clear hit the same pending bit at the same edge, the bit is left set.
- R8: `irq_o` equals the OR over bits 0 to 5 of pending AND enable (enable at 0x12, same bit order, bits 7:6 read 0). It updates at the same edge as the pending or enable change and stays high until the bits are cleared or disabled.
- R9: A byte write to the pending register is accepted without an error but leaves the pending bits unchanged.
- R10: The compare configuration byte drives `cfg_a_o` from its low nibble and `cfg_b_o` from its high nibble. `sel_a_o` and `sel_b_o` are bit 0 of the input select registers. The prescaler, clock control, mode and compare registers appear unchanged on their output ports.
- R11: `upd_i[j]` loads slot j of `upd_val_i` into value register j at the next edge. The slots are counter 1, capture A, capture B and counter 2 for j = 0..3. The load takes precedence over a bus write to the same register at the same edge.
- R12: A request sampled at an edge gives `rsp_valid`=1 for exactly the following cycle, and no request gives `rsp_valid`=0. Read data reflects the state before that edge, byte registers are zero-extended to 16 bits, and legal writes return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = halfword access, 0 = byte access |
| req_addr | input | ADDR_W | Byte address inside the window |
| req_wdata | input | DATA_W | Write data; byte writes use bits 7:0 |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Previous request was refused |
| rsp_rdata | output | DATA_W | Read data of the previous request |
| evt_i | input | NUM_EVT | Event strobes from the channels |
| upd_i | input | 4 | Load strobes for counters and captures |
| upd_val_i | input | 4*DATA_W | Load values, slot j at bits j*DATA_W up |
| prsc_o | output | BYTE_W | Prescaler register |
| clk_ctl_o | output | BYTE_W | Clock control register |
| mode_o | output | BYTE_W | Mode control register |
| cmp_a_o | output | DATA_W | Compare value A |
| cmp_b_o | output | DATA_W | Compare value B |
| cfg_a_o | output | BYTE_W/2 | Compare configuration for A |
| cfg_b_o | output | BYTE_W/2 | Compare configuration for B |
| sel_a_o | output | 1 | Input select for channel A |
| sel_b_o | output | 1 | Input select for channel B |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: a 5-bit address, 16-bit data, 8-bit byte registers and six events. This lets random addresses cover the whole 32-byte window, including odd addresses, the unmapped offset 0x1E and both widths at every offset. Six event bits with a six-bit clear mask make same-edge event/clear collisions reachable on every bit. Directed cases cover reset retention of the value registers and update-versus-write priority.

// File: rtl/tach_pkg.sv
package tach_pkg;

  // Register index = byte offset / 2; the order follows the address map.
  typedef enum logic [3:0] {
    SEL_CNT1 = 4'd0,
    SEL_CAPA = 4'd1,
    SEL_CAPB = 4'd2,
    SEL_CNT2 = 4'd3,
    SEL_PRSC = 4'd4,
    SEL_CLKC = 4'd5,
    SEL_MODE = 4'd6,
    SEL_PEND = 4'd7,
    SEL_CLR  = 4'd8,
    SEL_EN   = 4'd9,
    SEL_CMPA = 4'd10,
    SEL_CMPB = 4'd11,
    SEL_CCFG = 4'd12,
    SEL_INSA = 4'd13,
    SEL_INSB = 4'd14,
    SEL_NONE = 4'd15
  } reg_sel_e;

  localparam int NUM_VAL = 4;

  function automatic logic wide_reg(reg_sel_e s);
    return s inside {SEL_CNT1, SEL_CAPA, SEL_CAPB, SEL_CNT2, SEL_CMPA, SEL_CMPB};
  endfunction

endpackage

// File: rtl/tach_decode.sv
module tach_decode
  import tach_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wide,
  output reg_sel_e          sel,
  output logic              ok
);
  localparam int IDX_W = ADDR_W - 1;

  logic [IDX_W-1:0] idx;
  assign idx = addr[ADDR_W-1:1];

  always_comb begin
    sel = SEL_NONE;
    ok  = 1'b0;
    if (!addr[0] && (int'(idx) < int'(SEL_NONE))) begin
      if (wide == wide_reg(reg_sel_e'(idx[3:0]))) begin
        sel = reg_sel_e'(idx[3:0]);
        ok  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tach_pending.sv
module tach_pending #(
  parameter int NUM_EVT = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evt,
  input  logic [NUM_EVT-1:0] clr,
  input  logic [NUM_EVT-1:0] en_nxt,
  output logic [NUM_EVT-1:0] pend,
  output logic               irq
);
  logic [NUM_EVT-1:0] pend_nxt;

  generate
    for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
      // a new event overrides a clear aimed at the same bit
      assign pend_nxt[i] = evt[i] | (pend[i] & ~clr[i]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      irq  <= 1'b0;
    end else begin
      pend <= pend_nxt;
      irq  <= |(pend_nxt & en_nxt);
    end
  end
endmodule

// File: rtl/tach_regfile.sv
module tach_regfile
  import tach_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int BYTE_W  = 8,
  parameter int NUM_EVT = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  input  logic                       req_write,
  input  logic                       req_wide,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  output logic                       rsp_valid,
  output logic                       rsp_err,
  output logic [DATA_W-1:0]          rsp_rdata,
  input  logic [NUM_EVT-1:0]         evt_i,
  input  logic [3:0]                 upd_i,
  input  logic [4*DATA_W-1:0]        upd_val_i,
  output logic [BYTE_W-1:0]          prsc_o,
  output logic [BYTE_W-1:0]          clk_ctl_o,
  output logic [BYTE_W-1:0]          mode_o,
  output logic [DATA_W-1:0]          cmp_a_o,
  output logic [DATA_W-1:0]          cmp_b_o,
  output logic [BYTE_W/2-1:0]        cfg_a_o,
  output logic [BYTE_W/2-1:0]        cfg_b_o,
  output logic                       sel_a_o,
  output logic                       sel_b_o,
  output logic                       irq_o
);
  localparam int CFG_W = BYTE_W / 2;

  reg_sel_e sel;
  logic     ok;
  logic     wr;
  logic     rd;
  logic [3:0] sel_bits;

  tach_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (req_addr),
    .wide (req_wide),
    .sel  (sel),
    .ok   (ok)
  );

  assign wr       = req_valid & req_write & ok;
  assign rd       = req_valid & ~req_write & ok;
  assign sel_bits = sel;

  // Counter and capture values: loaded by channels or bus, never reset
  logic [NUM_VAL*DATA_W-1:0] val_flat;

  generate
    for (genvar j = 0; j < NUM_VAL; j++) begin : g_val
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (upd_i[j]) begin
          q <= upd_val_i[j*DATA_W +: DATA_W];
        end else if (wr && (sel_bits == 4'(j))) begin
          q <= req_wdata;
        end
      end
      assign val_flat[j*DATA_W +: DATA_W] = q;
    end
  endgenerate

  // Configuration registers
  logic [BYTE_W-1:0]  prsc_q, clkc_q, mode_q, ccfg_q, insa_q, insb_q;
  logic [DATA_W-1:0]  cmpa_q, cmpb_q;
  logic [NUM_EVT-1:0] en_q, en_nxt, clr_mask, pend_q;

  assign en_nxt   = (wr && sel == SEL_EN)  ? req_wdata[NUM_EVT-1:0] : en_q;
  assign clr_mask = (wr && sel == SEL_CLR) ? req_wdata[NUM_EVT-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      prsc_q <= '0;
      clkc_q <= '0;
      mode_q <= '0;
      ccfg_q <= '0;
      insa_q <= '0;
      insb_q <= '0;
      cmpa_q <= '0;
      cmpb_q <= '0;
      en_q   <= '0;
    end else begin
      en_q <= en_nxt;
      if (wr) begin
        case (sel)
          SEL_PRSC: prsc_q <= req_wdata[BYTE_W-1:0];
          SEL_CLKC: clkc_q <= req_wdata[BYTE_W-1:0];
          SEL_MODE: mode_q <= req_wdata[BYTE_W-1:0];
          SEL_CCFG: ccfg_q <= req_wdata[BYTE_W-1:0];
          SEL_INSA: insa_q <= req_wdata[BYTE_W-1:0];
          SEL_INSB: insb_q <= req_wdata[BYTE_W-1:0];
          SEL_CMPA: cmpa_q <= req_wdata;
          SEL_CMPB: cmpb_q <= req_wdata;
          default: ;
        endcase
      end
    end
  end

  tach_pending #(.NUM_EVT(NUM_EVT)) u_pend (
    .clk    (clk),
    .rst    (rst),
    .evt    (evt_i),
    .clr    (clr_mask),
    .en_nxt (en_nxt),
    .pend   (pend_q),
    .irq    (irq_o)
  );

  // Read multiplexer
  logic [DATA_W-1:0] rd_val;

  always_comb begin
    rd_val = '0;
    case (sel)
      SEL_CNT1, SEL_CAPA, SEL_CAPB, SEL_CNT2:
        rd_val = val_flat[sel_bits[1:0]*DATA_W +: DATA_W];
      SEL_PRSC: rd_val = DATA_W'(prsc_q);
      SEL_CLKC: rd_val = DATA_W'(clkc_q);
      SEL_MODE: rd_val = DATA_W'(mode_q);
      SEL_PEND: rd_val = DATA_W'(pend_q);
      SEL_EN:   rd_val = DATA_W'(en_q);
      SEL_CMPA: rd_val = cmpa_q;
      SEL_CMPB: rd_val = cmpb_q;
      SEL_CCFG: rd_val = DATA_W'(ccfg_q);
      SEL_INSA: rd_val = DATA_W'(insa_q);
      SEL_INSB: rd_val = DATA_W'(insb_q);
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid & ~ok;
      rsp_rdata <= rd ? rd_val : '0;
    end
  end

  assign prsc_o    = prsc_q;
  assign clk_ctl_o = clkc_q;
  assign mode_o    = mode_q;
  assign cmp_a_o   = cmpa_q;
  assign cmp_b_o   = cmpb_q;
  assign cfg_a_o   = ccfg_q[CFG_W-1:0];
  assign cfg_b_o   = ccfg_q[2*CFG_W-1:CFG_W];
  assign sel_a_o   = insa_q[0];
  assign sel_b_o   = insb_q[0];
endmodule

// File: rtl/tach_regfile_chk.sv
module tach_regfile_chk #(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int BYTE_W  = 8,
  parameter int NUM_EVT = 6,
  parameter int SNAP_W  = 6 * BYTE_W + 2 * DATA_W
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_write,
  input logic               req_wide,
  input logic [ADDR_W-1:0]  req_addr,
  input logic [NUM_EVT-1:0] clr_data,
  input logic               rsp_valid,
  input logic               rsp_err,
  input logic [DATA_W-1:0]  rsp_rdata,
  input logic [NUM_EVT-1:0] evt_i,
  input logic               irq_o,
  input logic [NUM_EVT-1:0] pend,
  input logic [NUM_EVT-1:0] en,
  input logic [SNAP_W-1:0]  snap
);
  localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(16);

  logic [NUM_EVT-1:0] clr_mask;
  assign clr_mask = (req_valid && req_write && !req_wide && req_addr == CLR_ADDR)
                    ? clr_data : '0;

  a_r1_err_reads_zero: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_rdata == '0));

  a_r2_reject_keeps_state: assert property (@(posedge clk) disable iff (rst)
    (rsp_err && $past(req_write)) |-> ($stable(snap) && $stable(en)));

  a_r5_event_sets_pending: assert property (@(posedge clk) disable iff (rst)
    (|evt_i) |=> ((pend & $past(evt_i)) == $past(evt_i)));

  a_r6_drop_needs_clear: assert property (@(posedge clk) disable iff (rst)
    (|pend) |=> (($past(pend) & ~pend & ~$past(clr_mask)) == '0));

  a_r7_event_beats_clear: assert property (@(posedge clk) disable iff (rst)
    (|(evt_i & clr_mask)) |=> ((pend & $past(evt_i & clr_mask)) == $past(evt_i & clr_mask)));

  a_r8_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|(pend & en)));

  a_r12_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  a_r12_no_rsp_when_idle: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
endmodule

bind tach_regfile tach_regfile_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .BYTE_W  (BYTE_W),
  .NUM_EVT (NUM_EVT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_wide  (req_wide),
  .req_addr  (req_addr),
  .clr_data  (req_wdata[NUM_EVT-1:0]),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_rdata (rsp_rdata),
  .evt_i     (evt_i),
  .irq_o     (irq_o),
  .pend      (pend_q),
  .en        (en_q),
  .snap      ({prsc_q, clkc_q, mode_q, ccfg_q, insa_q, insb_q, cmpa_q, cmpb_q})
);

// File: tb/tach_regfile_tb.sv
module tach_regfile_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [15:0] rsp_rdata;
  logic [5:0]  evt_i = '0;
  logic [3:0]  upd_i = '0;
  logic [63:0] upd_val_i = '0;
  logic [7:0]  prsc_o, clk_ctl_o, mode_o;
  logic [15:0] cmp_a_o, cmp_b_o;
  logic [3:0]  cfg_a_o, cfg_b_o;
  logic        sel_a_o, sel_b_o, irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #10 clk = ~clk;

  tach_regfile u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .evt_i(evt_i), .upd_i(upd_i), .upd_val_i(upd_val_i),
    .prsc_o(prsc_o), .clk_ctl_o(clk_ctl_o), .mode_o(mode_o),
    .cmp_a_o(cmp_a_o), .cmp_b_o(cmp_b_o), .cfg_a_o(cfg_a_o), .cfg_b_o(cfg_b_o),
    .sel_a_o(sel_a_o), .sel_b_o(sel_b_o), .irq_o(irq_o)
  );

  // Reference model
  logic [15:0] m_reg [16];
  logic [5:0]  m_pend;

  function automatic logic is_wide(int idx);
    return (idx <= 3) || (idx == 10) || (idx == 11);
  endfunction

  function automatic logic legal(logic [4:0] a, logic wd);
    int idx = int'(a[4:1]);
    return (a[0] == 1'b0) && (idx <= 14) && (wd == is_wide(idx));
  endfunction

  function automatic logic [15:0] mread(int idx);
    if (idx == 8) return 16'h0;
    if (idx == 7) return {10'h0, m_pend};
    return m_reg[idx];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 4; i < 16; i++) m_reg[i] = 16'h0;
    m_pend = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  task automatic op(input string tag, input logic w, input logic wd, input logic [4:0] a,
                    input logic [15:0] d, input logic [5:0] ev, input logic [3:0] up,
                    input logic [63:0] uv);
    logic ok;
    logic [15:0] er;
    logic [5:0] clr;
    int idx;
    idx = int'(a[4:1]);
    ok  = legal(a, wd);
    er  = (ok && !w) ? mread(idx) : 16'h0;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_wide = wd; req_addr = a; req_wdata = d;
    evt_i = ev; upd_i = up; upd_val_i = uv;
    @(negedge clk);
    req_valid = 1'b0; evt_i = '0; upd_i = '0;
    clr = '0;
    if (ok && w) begin
      case (idx)
        7: ;
        8: clr = d[5:0];
        9: m_reg[9] = {10'h0, d[5:0]};
        0, 1, 2, 3, 10, 11: m_reg[idx] = d;
        default: m_reg[idx] = {8'h0, d[7:0]};
      endcase
    end
    for (int j = 0; j < 4; j++) if (up[j]) m_reg[j] = uv[j*16 +: 16];
    m_pend = (m_pend & ~clr) | ev;
    check({tag, " R12 rsp_valid"}, 32'(rsp_valid), 32'(1));
    check({tag, " R1 rsp_err"}, 32'(rsp_err), 32'(!ok));
    check({tag, " R12 rdata"}, 32'(rsp_rdata), 32'(er));
    check({tag, " R8 irq"}, 32'(irq_o), 32'(|(m_pend & m_reg[9][5:0])));
  endtask

  task automatic rd(input string tag, input logic [4:0] a, input logic wd);
    op(tag, 1'b0, wd, a, 16'h0, 6'h0, 4'h0, 64'h0);
  endtask

  task automatic wr(input string tag, input logic [4:0] a, input logic wd, input logic [15:0] d);
    op(tag, 1'b1, wd, a, d, 6'h0, 4'h0, 64'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 16; i++) m_reg[i] = 16'h0;
    m_pend = '0;
    do_reset();

    // R3: reset state
    check("R3 rsp_valid", 32'(rsp_valid), 0);
    check("R3 irq", 32'(irq_o), 0);
    check("R3 outputs", {prsc_o, clk_ctl_o, mode_o, cfg_a_o, cfg_b_o},
          32'h0);
    check("R3 compare", {cmp_a_o, cmp_b_o}, 32'h0);
    for (int i = 4; i < 15; i++) rd("R3 read", 5'(i*2), is_wide(i));

    // R11/R4: fill value registers, then reset and read back
    for (int i = 0; i < 4; i++) wr("R4 fill", 5'(i*2), 1'b1, 16'h1111 * 16'(i+1) + 16'h0A0B);
    wr("R3 dirty", 5'h08, 1'b0, 16'h00C3);
    do_reset();
    check("R3 prescaler after reset", 32'(prsc_o), 0);
    for (int i = 0; i < 4; i++) rd("R4 retain", 5'(i*2), 1'b1);

    // R10: configuration outputs
    wr("R10 ccfg", 5'h18, 1'b0, 16'hFFA5);
    check("R10 cfg_a", 32'(cfg_a_o), 32'h5);
    check("R10 cfg_b", 32'(cfg_b_o), 32'hA);
    wr("R10 insa", 5'h1A, 1'b0, 16'h00FE);
    wr("R10 insb", 5'h1C, 1'b0, 16'h0001);
    check("R10 sel", {sel_a_o, sel_b_o}, 32'h1);
    wr("R10 prsc", 5'h08, 1'b0, 16'h3C5A);
    wr("R10 mode", 5'h0C, 1'b0, 16'h0044);
    wr("R10 cmpa", 5'h14, 1'b1, 16'hBEEF);
    check("R10 prsc_o", 32'(prsc_o), 32'h5A);
    check("R10 mode_o", 32'(mode_o), 32'h44);
    check("R10 cmp_a_o", 32'(cmp_a_o), 32'hBEEF);
    rd("R12 byte zero-extend", 5'h08, 1'b0);

    // R1/R2: refused accesses
    wr("R2 wide to prsc", 5'h08, 1'b1, 16'h7777);
    check("R2 prsc kept", 32'(prsc_o), 32'h5A);
    wr("R2 byte to cmpa", 5'h14, 1'b0, 16'h0011);
    check("R2 cmpa kept", 32'(cmp_a_o), 32'hBEEF);
    wr("R2 unmapped", 5'h1E, 1'b0, 16'h00FF);
    wr("R2 odd", 5'h09, 1'b0, 16'h00FF);
    check("R2 prsc kept 2", 32'(prsc_o), 32'h5A);
    rd("R1 wide read of byte reg", 5'h0C, 1'b1);
    rd("R1 byte read of counter", 5'h00, 1'b0);
    rd("R1 odd read", 5'h03, 1'b1);
    rd("R1 unmapped read", 5'h1E, 1'b0);

    // R5: each event sets its own bit, no interrupt while disabled
    for (int k = 0; k < 6; k++) begin
      op("R5 event", 1'b0, 1'b0, 5'h0E, 16'h0, 6'(1 << k), 4'h0, 64'h0);
      rd("R5 pending read", 5'h0E, 1'b0);
      wr("R6 clear one", 5'h10, 1'b0, 16'(1 << k));
    end
    rd("R5 pending empty", 5'h0E, 1'b0);
    @(negedge clk);
    check("R12 idle rsp_valid", 32'(rsp_valid), 0);

    // R8: enable gating
    op("R8 event b3", 1'b0, 1'b0, 5'h0E, 16'h0, 6'h08, 4'h0, 64'h0);
    check("R8 irq off while disabled", 32'(irq_o), 0);
    wr("R8 enable b3", 5'h12, 1'b0, 16'h00C8);
    check("R8 irq on", 32'(irq_o), 1);
    rd("R8 enable readback", 5'h12, 1'b0);
    rd("R6 clear reads zero", 5'h10, 1'b0);
    wr("R6 clear other bits", 5'h10, 1'b0, 16'h0037);
    check("R8 irq held", 32'(irq_o), 1);
    wr("R6 clear b3", 5'h10, 1'b0, 16'h0008);
    check("R8 irq dropped", 32'(irq_o), 0);

    // R7: event and clear on the same bit at the same edge
    op("R7 preset", 1'b0, 1'b0, 5'h0E, 16'h0, 6'h21, 4'h0, 64'h0);
    op("R7 collide", 1'b1, 1'b0, 5'h10, 16'h0021, 6'h01, 4'h0, 64'h0);
    rd("R7 bit0 kept bit5 cleared", 5'h0E, 1'b0);

    // R9: pending ignores bus writes
    wr("R9 write pending", 5'h0E, 1'b0, 16'h003E);
    rd("R9 pending unchanged", 5'h0E, 1'b0);

    // R11: channel load beats bus write
    op("R11 collide", 1'b1, 1'b1, 5'h02, 16'h1234, 6'h0, 4'b0010, {16'h0, 16'h0, 16'hCAFE, 16'h0});
    rd("R11 capture A", 5'h02, 1'b1);
    op("R11 load all", 1'b0, 1'b0, 5'h0E, 16'h0, 6'h0, 4'hF, 64'h4444_3333_2222_1111);
    for (int i = 0; i < 4; i++) rd("R11 readback", 5'(i*2), 1'b1);

    // Random traffic
    for (int n = 0; n < 500; n++) begin
      logic [4:0] a;
      logic wd, w;
      logic [5:0] ev;
      if ($urandom_range(0, 3) != 0) begin
        int idx = $urandom_range(0, 14);
        a  = 5'(idx * 2);
        wd = is_wide(idx);
      end else begin
        a  = 5'($urandom_range(0, 31));
        wd = 1'($urandom_range(0, 1));
      end
      w  = 1'($urandom_range(0, 1));
      ev = ($urandom_range(0, 2) == 0) ? 6'($urandom()) : 6'h0;
      op("R5 R6 R7 random", w, wd, a, 16'($urandom()), ev, 4'h0, 64'h0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule